// File: doc/BRIEF.md
# Character-Based Raster Timing Generator

This block produces the scan timing for a character-oriented video controller. Horizontally, a line is built from four consecutive intervals (sync, back porch, active, front porch), each counted in character units of eight pixel-clock enables. Vertically, a frame is built from four intervals counted in whole lines. All eight interval lengths come from register-style inputs, and it generates hsync, vsync and an active-display window from them.

Alongside the timing, the block keeps a scanline raster counter. The counter is preset to 64 on the line immediately before the first visible line. When the counter matches a compare value, the block can raise an interrupt pulse. It can also raise a pulse on the first line after the visible window closes. The horizontal and vertical scroll values that the renderer sees are sampled at line boundaries, so a host write never changes them partway through a line.

Top module: `raster_timing_gen`

## Requirements
- R1: After reset, hsync and vsync are 1, disp_active, line_start, rc_irq and vb_irq are 0, and raster_cnt, scroll_x and scroll_y are 0.
- R2: Each line runs through four intervals in a fixed order: sync for hsw+1 characters, then back porch for hds+1, then active for hdw+1, then front porch for hde+1. A character is 8 pix_en cycles. hsync is 1 exactly during the sync interval.
- R3: A clock with pix_en low changes no timing state, no output level and no counter.
- R4: disp_active is 1 only while the horizontal active interval falls on a line of the vertical active interval.
- R5: Each frame runs through four line intervals in order: sync for vsw+1 lines (vsync=1), then back porch for vds+2 lines, then active for vdw+1 lines, then front porch for vcr lines. When vcr is 0, the front porch is skipped.
- R6: line_start is a one-clock pulse in the clock that follows the enable edge that ends a line.
- R7: raster_cnt counts from 0 after reset and advances by 1 at each line end, wrapping at 10 bits. When the last back-porch line begins, it is loaded with 64 instead.
- R8: rc_irq pulses together with line_start when rc_irq_en is 1 and the raster_cnt value of the new line equals rcr.
- R9: vb_irq pulses together with line_start when vb_irq_en is 1 and the new line is the first line after the vertical active interval.
- R10: scroll_x takes the value of scroll_x_in at each line end and holds it for the whole line.
- R11: A scroll_y_wr strobe makes scroll_y equal scroll_y_in+1 (9-bit) at the next line end. The value of scroll_y_in at that line end is used. At every other line end, scroll_y advances by 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pix_en | input | 1 | Pixel-clock enable |
| hsw | input | 5 | Horizontal sync width, characters minus 1 |
| hds | input | 7 | Horizontal back porch, characters minus 1 |
| hdw | input | 7 | Horizontal active width, characters minus 1 |
| hde | input | 7 | Horizontal front porch, characters minus 1 |
| vsw | input | 5 | Vertical sync width, lines minus 1 |
| vds | input | 8 | Vertical back porch, lines minus 2 |
| vdw | input | 9 | Vertical active height, lines minus 1 |
| vcr | input | 8 | Vertical front porch, lines |
| rcr | input | 10 | Raster compare value |
| rc_irq_en | input | 1 | Raster match interrupt enable |
| vb_irq_en | input | 1 | Vertical blank interrupt enable |
| scroll_x_in | input | 10 | Host X scroll value |
| scroll_y_in | input | 9 | Host Y scroll value |
| scroll_y_wr | input | 1 | Host Y scroll write strobe |
| hsync | output | 1 | Horizontal sync, active high |
| vsync | output | 1 | Vertical sync, active high |
| disp_active | output | 1 | Active display window |
| line_start | output | 1 | New line strobe |
| scroll_x | output | 10 | X scroll for the current line |
| scroll_y | output | 9 | Y scroll for the current line |
| raster_cnt | output | 10 | Raster counter |
| rc_irq | output | 1 | Raster match interrupt pulse |
| vb_irq | output | 1 | Vertical blank interrupt pulse |

## Verification
On every cycle, the assertions check the local invariants. With pix_en low, nothing moves. Both interrupt pulses coincide with line_start, and line_start never lasts two clocks. The raster counter and the X scroll value change only on a line_start clock. The window is never open during a sync. The interval lengths, the preset of 64, the compare hits and the Y-scroll offset of one cannot be expressed as single-cycle properties. The bench's scenarios show them by comparing every output against a position-based model across whole frames, under randomized and minimal or maximal field settings.

// File: rtl/raster_timing_gen.sv
module raster_timing_gen #(
  parameter int RASTER_PRESET = 64
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pix_en,
  input  logic [4:0] hsw,
  input  logic [6:0] hds,
  input  logic [6:0] hdw,
  input  logic [6:0] hde,
  input  logic [4:0] vsw,
  input  logic [7:0] vds,
  input  logic [8:0] vdw,
  input  logic [7:0] vcr,
  input  logic [9:0] rcr,
  input  logic       rc_irq_en,
  input  logic       vb_irq_en,
  input  logic [9:0] scroll_x_in,
  input  logic [8:0] scroll_y_in,
  input  logic       scroll_y_wr,
  output logic       hsync,
  output logic       vsync,
  output logic       disp_active,
  output logic       line_start,
  output logic [9:0] scroll_x,
  output logic [8:0] scroll_y,
  output logic [9:0] raster_cnt,
  output logic       rc_irq,
  output logic       vb_irq
);

  typedef enum logic [1:0] {PH_SYNC, PH_START, PH_DISP, PH_END} phase_t;

  phase_t     hph, vph;
  logic [2:0] px;
  logic [6:0] hcnt;
  logic [8:0] vcnt;
  logic       y_pend;
  logic [6:0] hlim;
  logic [8:0] vlim;

  always_comb begin
    case (hph)
      PH_SYNC:  hlim = {2'b00, hsw};
      PH_START: hlim = hds;
      PH_DISP:  hlim = hdw;
      default:  hlim = hde;
    endcase
    case (vph)
      PH_SYNC:  vlim = {4'b0000, vsw};
      PH_START: vlim = {1'b0, vds} + 9'd1;
      PH_DISP:  vlim = vdw;
      default:  vlim = {1'b0, vcr} - 9'd1;
    endcase
  end

  wire        char_end  = pix_en && (px == 3'd7);
  wire        line_end  = char_end && (hcnt == hlim) && (hph == PH_END);
  wire        vdone     = (vcnt == vlim);
  wire        preset    = (vph == PH_START) && (vcnt == {1'b0, vds});
  wire [9:0]  rc_next   = preset ? 10'(RASTER_PRESET) : raster_cnt + 10'd1;
  wire phase_t vph_next = (vph == PH_DISP && vcr == 8'd0) ? PH_SYNC : phase_t'(vph + 2'd1);

  assign hsync       = (hph == PH_SYNC);
  assign vsync       = (vph == PH_SYNC);
  assign disp_active = (hph == PH_DISP) && (vph == PH_DISP);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hph        <= PH_SYNC;
      vph        <= PH_SYNC;
      px         <= '0;
      hcnt       <= '0;
      vcnt       <= '0;
      y_pend     <= 1'b0;
      line_start <= 1'b0;
      rc_irq     <= 1'b0;
      vb_irq     <= 1'b0;
      raster_cnt <= '0;
      scroll_x   <= '0;
      scroll_y   <= '0;
    end else begin
      line_start <= line_end;
      rc_irq     <= line_end && rc_irq_en && (rc_next == rcr);
      vb_irq     <= line_end && vb_irq_en && (vph == PH_DISP) && vdone;
      if (pix_en) px <= px + 3'd1;
      if (char_end) begin
        if (hcnt == hlim) begin
          hcnt <= '0;
          hph  <= phase_t'(hph + 2'd1);
        end else begin
          hcnt <= hcnt + 7'd1;
        end
      end
      if (line_end) begin
        if (vdone) begin
          vcnt <= '0;
          vph  <= vph_next;
        end else begin
          vcnt <= vcnt + 9'd1;
        end
        raster_cnt <= rc_next;
        scroll_x   <= scroll_x_in;
        scroll_y   <= (y_pend || scroll_y_wr) ? scroll_y_in + 9'd1 : scroll_y + 9'd1;
        y_pend     <= 1'b0;
      end else if (scroll_y_wr) begin
        y_pend <= 1'b1;
      end
    end
  end

endmodule

module raster_timing_gen_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       pix_en,
  input logic       hsync,
  input logic       vsync,
  input logic       disp_active,
  input logic       line_start,
  input logic [9:0] raster_cnt,
  input logic [9:0] scroll_x,
  input logic       rc_irq,
  input logic       vb_irq
);

  p_freeze_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !pix_en |=> ($stable(hsync) && $stable(vsync) && $stable(raster_cnt) && !line_start));

  p_window_r4: assert property (@(posedge clk) disable iff (!rst_n)
    disp_active |-> (!hsync && !vsync));

  p_single_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    line_start |=> !line_start);

  p_raster_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !line_start |-> $stable(raster_cnt));

  p_match_aligned_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rc_irq |-> line_start);

  p_vblank_aligned_r9: assert property (@(posedge clk) disable iff (!rst_n)
    vb_irq |-> line_start);

  p_xscroll_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !line_start |-> $stable(scroll_x));

endmodule

bind raster_timing_gen raster_timing_gen_chk u_chk (
  .clk(clk), .rst_n(rst_n), .pix_en(pix_en), .hsync(hsync), .vsync(vsync),
  .disp_active(disp_active), .line_start(line_start), .raster_cnt(raster_cnt),
  .scroll_x(scroll_x), .rc_irq(rc_irq), .vb_irq(vb_irq)
);

// File: tb/raster_timing_gen_bench.sv
module raster_timing_gen_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pix_en = 1'b0;
  logic [4:0] hsw = '0;
  logic [6:0] hds = '0, hdw = '0, hde = '0;
  logic [4:0] vsw = '0;
  logic [7:0] vds = '0;
  logic [8:0] vdw = '0;
  logic [7:0] vcr = '0;
  logic [9:0] rcr = '0;
  logic rc_irq_en = 1'b0, vb_irq_en = 1'b0;
  logic [9:0] scroll_x_in = '0;
  logic [8:0] scroll_y_in = '0;
  logic scroll_y_wr = 1'b0;
  logic hsync, vsync, disp_active, line_start, rc_irq, vb_irq;
  logic [9:0] scroll_x, raster_cnt;
  logic [8:0] scroll_y;

  int errors = 0;
  int checks = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  raster_timing_gen u_raster_timing_gen (
    .clk(clk), .rst_n(rst_n), .pix_en(pix_en),
    .hsw(hsw), .hds(hds), .hdw(hdw), .hde(hde),
    .vsw(vsw), .vds(vds), .vdw(vdw), .vcr(vcr),
    .rcr(rcr), .rc_irq_en(rc_irq_en), .vb_irq_en(vb_irq_en),
    .scroll_x_in(scroll_x_in), .scroll_y_in(scroll_y_in), .scroll_y_wr(scroll_y_wr),
    .hsync(hsync), .vsync(vsync), .disp_active(disp_active), .line_start(line_start),
    .scroll_x(scroll_x), .scroll_y(scroll_y), .raster_cnt(raster_cnt),
    .rc_irq(rc_irq), .vb_irq(vb_irq)
  );

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int line_len();
    return 8 * (int'(hsw) + int'(hds) + int'(hdw) + int'(hde) + 4);
  endfunction

  function automatic int frame_len();
    return int'(vsw) + int'(vds) + int'(vdw) + int'(vcr) + 4;
  endfunction

  function automatic int exp_raster(int ln);
    int p;
    p = int'(vsw) + int'(vds) + 2;
    if (ln < p) return ln % 1024;
    return (64 + (ln - p) % frame_len()) % 1024;
  endfunction

  function automatic bit exp_hdisp(int pos);
    int a;
    a = 8 * (int'(hsw) + int'(hds) + 2);
    return (pos >= a) && (pos < a + 8 * (int'(hdw) + 1));
  endfunction

  function automatic bit exp_vdisp(int lf);
    int a;
    a = int'(vsw) + int'(vds) + 3;
    return (lf >= a) && (lf < a + int'(vdw) + 1);
  endfunction

  task automatic run_case(int cycles, bit rnd_en);
    int n, len, frm, ln, lf, pos, sx, sy;
    bit pend, last_en, ended, ex_rc, ex_vb;
    string rq;
    rst_n = 1'b0; pix_en = 1'b0; scroll_y_wr = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    chk("R1", "hsync", hsync, 1); chk("R1", "vsync", vsync, 1);
    chk("R1", "disp", disp_active, 0); chk("R1", "raster", raster_cnt, 0);
    chk("R1", "sx", scroll_x, 0); chk("R1", "sy", scroll_y, 0);
    chk("R1", "pulses", {line_start, rc_irq, vb_irq}, 0);
    rst_n = 1'b1;
    n = 0; sx = 0; sy = 0; pend = 0; last_en = 1; ended = 0; ex_rc = 0; ex_vb = 0;
    len = line_len(); frm = frame_len();
    for (int c = 0; c < cycles; c++) begin
      pix_en = rnd_en ? (($urandom % 4) != 0) : 1'b1;
      if (($urandom % 20) == 0) scroll_x_in = 10'($urandom);
      scroll_y_wr = (($urandom % 60) == 0);
      if (scroll_y_wr) scroll_y_in = 9'($urandom);
      @(posedge clk);
      last_en = pix_en;
      ended = 0;
      if (pix_en) begin
        n++;
        ended = (n % len) == 0;
      end
      if (ended) begin
        sx = int'(scroll_x_in);
        sy = (pend || scroll_y_wr) ? (int'(scroll_y_in) + 1) % 512 : (sy + 1) % 512;
        pend = 0;
      end else if (scroll_y_wr) pend = 1;
      ln = n / len; lf = ln % frm; pos = n % len;
      ex_rc = ended && rc_irq_en && (exp_raster(ln) == int'(rcr));
      ex_vb = ended && vb_irq_en && (lf == (int'(vsw) + int'(vds) + int'(vdw) + 4) % frm);
      @(negedge clk);
      rq = last_en ? "R2" : "R3";
      chk(rq, "hsync", hsync, int'(pos < 8 * (int'(hsw) + 1)));
      chk("R5", "vsync", vsync, int'(lf <= int'(vsw)));
      chk("R4", "disp", disp_active, int'(exp_hdisp(pos) && exp_vdisp(lf)));
      chk("R6", "line_start", line_start, int'(ended));
      chk(last_en ? "R7" : "R3", "raster", raster_cnt, exp_raster(ln));
      chk("R8", "rc_irq", rc_irq, int'(ex_rc));
      chk("R9", "vb_irq", vb_irq, int'(ex_vb));
      chk("R10", "scroll_x", scroll_x, sx);
      chk("R11", "scroll_y", scroll_y, sy);
    end
    scroll_y_wr = 1'b0;
  endtask

  initial begin
    int cyc;
    void'($urandom(32'h5EED_0077));
    // minimal fields, front porch skipped
    hsw = 0; hds = 0; hdw = 0; hde = 0; vsw = 0; vds = 0; vdw = 0; vcr = 0;
    rcr = 10'd65; rc_irq_en = 1; vb_irq_en = 1;
    run_case(400, 0);
    // maximal horizontal fields, short frame
    hsw = 31; hds = 127; hdw = 127; hde = 127; vsw = 0; vds = 0; vdw = 1; vcr = 1;
    rcr = 10'd64; rc_irq_en = 1; vb_irq_en = 1;
    run_case(3328 * 6 + 50, 0);
    // randomized configurations with gated pixel enables
    for (int s = 0; s < 8; s++) begin
      hsw = 5'($urandom % 4); hds = 7'($urandom % 4); hdw = 7'($urandom % 8); hde = 7'($urandom % 4);
      vsw = 5'($urandom % 3); vds = 8'($urandom % 4); vdw = 9'($urandom % 10); vcr = 8'($urandom % 4);
      rcr = 10'(64 + $urandom % 12);
      rc_irq_en = (s != 3); vb_irq_en = (s != 5);
      cyc = line_len() * frame_len() * 2 + 100;
      if (cyc > 9000) cyc = 9000;
      run_case(cyc, 1);
    end
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    #1900000;
    if (!finished) begin
      finished = 1;
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule